// File: doc/BRIEF.md
# Grid-Cycle Hill-Climbing Power Tracker

This block steers a photovoltaic array towards its maximum power point for a single-stage inverter that feeds the grid. It takes a stream of array voltage and array current samples together with a strobe that marks the start of each grid fundamental cycle. It does not act on single samples. Over each window between two strobes it sums the samples, divides each sum by the number of samples it took, and multiplies the two means to get the average power of that window. Averaging over a whole cycle cancels the power ripple at twice the grid frequency, which would otherwise push the tracker the wrong way.

A hill-climbing engine compares each window's power with the power of the window before it. It keeps its step direction while power does not drop and reverses the direction when power falls. It then moves a pending modulation index by a fixed step and holds that index between a lower and an upper bound. The PWM stage never sees the pending value directly. The index handed out is registered only on a cycle-start strobe, so the modulation depth stays constant across every fundamental cycle. Raising the index draws more current and pulls the array voltage down. Lowering it lets the array voltage rise.

Top module: `mppt_cycle_tracker`

## Requirements
- R1: While reset is asserted and after it is released, `idx_out` equals IDX_INIT and `idx_valid` is 0 until the first strobe.
- R2: `idx_out` changes only on a clock edge where `cyc_start` is sampled high. `idx_valid` is 1 for exactly the one cycle that follows such an edge.
- R3: The value latched on a strobe is the pending index. The pending index holds the result of the decision on the window that the previous strobe closed, or IDX_INIT if no decision has been made yet.
- R4: A window's mean voltage and mean current are each floor(sum / count). Only samples with `smp_valid` high are counted. A sample that comes in the same cycle as the strobe belongs to the new window.
- R5: Window power is mean voltage times mean current. The previous power starts at 0. If the new power is lower than the previous power, the direction reverses; otherwise it is kept.
- R6: The direction starts as increase. Increase adds IDX_STEP to the index and decrease subtracts it.
- R7: A step that would go above IDX_MAX or below IDX_MIN stops at that limit. On the next decision the direction is reversed, whatever the power comparison gives. Landing exactly on a limit does not count as going past it.
- R8: A window with no samples makes no decision. The pending index, the direction and the previous power all stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe for `smp_volt` and `smp_curr` |
| smp_volt | input | SMP_W | Array voltage sample, unsigned |
| smp_curr | input | SMP_W | Array current sample, unsigned |
| cyc_start | input | 1 | Start of a grid fundamental cycle, one clock wide |
| idx_out | output | IDX_W | Modulation index handed to the PWM stage |
| idx_valid | output | 1 | One-clock pulse after `idx_out` is latched |

## Verification
`idx_out` and `idx_valid` are registered on the strobe edge, so the bench samples them on the falling edge right after it. One cycle later it checks that `idx_valid` has dropped and that the index has not moved. The decision on a closed window comes through a snapshot register, a serial divider of SMP_W+CNT_W cycles, a product register and the step register. That is about SMP_W+CNT_W+3 cycles after the strobe, so its result can only be seen at the next strobe. The bench keeps every strobe at least 20 cycles after the previous one and compares each latched index with a pending value that it computes itself.

// File: rtl/trk_pkg.sv
package trk_pkg;
   typedef enum logic {
      DIR_DN = 1'b0,
      DIR_UP = 1'b1
   } trk_dir_e;

   localparam int unsigned TRK_CH = 2;   // channel 0 voltage, channel 1 current
endpackage

// File: rtl/trk_win_acc.sv
module trk_win_acc #(
   parameter int unsigned SMP_W = 12,
   parameter int unsigned CNT_W = 10,
   localparam int unsigned ACC_W = SMP_W + CNT_W
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  smp_valid,
   input  logic [trk_pkg::TRK_CH-1:0][SMP_W-1:0] smp,
   input  logic                                  cyc_start,
   output logic [trk_pkg::TRK_CH-1:0][ACC_W-1:0] snap_sum,
   output logic [CNT_W-1:0]                      snap_cnt,
   output logic                                  snap_vld
);
   logic [CNT_W-1:0] cnt_r;
   logic             take;

   // count saturates: further samples in an overlong window are dropped
   assign take = smp_valid && (cnt_r != {CNT_W{1'b1}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_r    <= '0;
         snap_cnt <= '0;
         snap_vld <= 1'b0;
      end else begin
         snap_vld <= cyc_start;
         if (cyc_start) begin
            snap_cnt <= cnt_r;
            cnt_r    <= smp_valid ? CNT_W'(1) : '0;
         end else if (take) begin
            cnt_r <= cnt_r + CNT_W'(1);
         end
      end
   end

   for (genvar ch = 0; ch < trk_pkg::TRK_CH; ch++) begin : g_ch
      logic [ACC_W-1:0] sum_r;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sum_r       <= '0;
            snap_sum[ch] <= '0;
         end else if (cyc_start) begin
            snap_sum[ch] <= sum_r;
            sum_r        <= smp_valid ? ACC_W'(smp[ch]) : '0;
         end else if (take) begin
            sum_r <= sum_r + ACC_W'(smp[ch]);
         end
      end

      // R4: a window sum never exceeds count times the largest sample
      sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         snap_vld |-> (snap_sum[ch] <= ACC_W'(snap_cnt) * ACC_W'({SMP_W{1'b1}})));
   end
endmodule

// File: rtl/trk_seq_div.sv
module trk_seq_div #(
   parameter int unsigned NUM_W = 22,
   parameter int unsigned DEN_W = 10,
   localparam int unsigned K_W  = $clog2(NUM_W + 1),
   localparam int unsigned T_W  = DEN_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [NUM_W-1:0] num,
   input  logic [DEN_W-1:0] den,
   output logic             busy,
   output logic             done,
   output logic [NUM_W-1:0] quo
);
   logic [DEN_W-1:0] rem_r, den_r;
   logic [K_W-1:0]   k_r;
   logic [T_W-1:0]   trial;
   logic             ge;

   if (NUM_W < 2) begin : g_bad_num
      $error("trk_seq_div: NUM_W must be at least 2");
   end

   assign trial = {rem_r, quo[NUM_W-1]};
   assign ge    = trial >= {1'b0, den_r};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         quo   <= '0;
         rem_r <= '0;
         den_r <= '0;
         k_r   <= '0;
         busy  <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy && start) begin
            quo   <= num;
            rem_r <= '0;
            den_r <= den;
            k_r   <= K_W'(NUM_W);
            busy  <= 1'b1;
         end else if (busy) begin
            rem_r <= ge ? DEN_W'(trial - {1'b0, den_r}) : trial[DEN_W-1:0];
            quo   <= {quo[NUM_W-2:0], ge};
            k_r   <= k_r - K_W'(1);
            if (k_r == K_W'(1)) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   // R4: restoring division leaves a remainder below the divisor
   rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (rem_r < den_r));
endmodule

// File: rtl/trk_step_ctl.sv
module trk_step_ctl #(
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned PWR_W    = 24,
   parameter int unsigned IDX_MIN  = 64,
   parameter int unsigned IDX_MAX  = 900,
   parameter int unsigned IDX_INIT = 300,
   parameter int unsigned IDX_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             dec_en,
   input  logic [PWR_W-1:0] pwr,
   output logic [IDX_W-1:0] pend
);
   import trk_pkg::*;

   localparam logic [IDX_W:0] MIN_X  = (IDX_W+1)'(IDX_MIN);
   localparam logic [IDX_W:0] MAX_X  = (IDX_W+1)'(IDX_MAX);
   localparam logic [IDX_W:0] STEP_X = (IDX_W+1)'(IDX_STEP);
   localparam logic [IDX_W:0] LOW_X  = MIN_X + STEP_X;

   trk_dir_e         dir_r, dir_n;
   logic             hit_r, sat_n;
   logic [PWR_W-1:0] prev_r;
   logic [IDX_W:0]   up_x;
   logic [IDX_W-1:0] cand;

   always_comb begin
      dir_n = dir_r;
      if (hit_r)
         dir_n = (dir_r == DIR_UP) ? DIR_DN : DIR_UP;
      else if (pwr < prev_r)
         dir_n = (dir_r == DIR_UP) ? DIR_DN : DIR_UP;
   end

   assign up_x = {1'b0, pend} + STEP_X;

   always_comb begin
      sat_n = 1'b0;
      if (dir_n == DIR_UP) begin
         if (up_x > MAX_X) begin
            cand  = MAX_X[IDX_W-1:0];
            sat_n = 1'b1;
         end else begin
            cand = up_x[IDX_W-1:0];
         end
      end else begin
         if ({1'b0, pend} < LOW_X) begin
            cand  = MIN_X[IDX_W-1:0];
            sat_n = 1'b1;
         end else begin
            cand = pend - STEP_X[IDX_W-1:0];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend   <= IDX_W'(IDX_INIT);
         dir_r  <= DIR_UP;
         hit_r  <= 1'b0;
         prev_r <= '0;
      end else if (dec_en) begin
         pend   <= cand;
         dir_r  <= dir_n;
         hit_r  <= sat_n;
         prev_r <= pwr;
      end
   end

   // R7
   idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend >= IDX_W'(IDX_MIN)) && (pend <= IDX_W'(IDX_MAX)));
   // R6
   step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec_en |=> (((pend >= $past(pend)) ? (pend - $past(pend)) : ($past(pend) - pend))
                  <= IDX_W'(IDX_STEP)));
   // R8
   no_dec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dec_en |=> $stable(pend));
endmodule

// File: rtl/mppt_cycle_tracker.sv
module mppt_cycle_tracker #(
   parameter int unsigned SMP_W    = 12,
   parameter int unsigned CNT_W    = 10,
   parameter int unsigned IDX_W    = 10,
   parameter int unsigned IDX_MIN  = 64,
   parameter int unsigned IDX_MAX  = 900,
   parameter int unsigned IDX_INIT = 300,
   parameter int unsigned IDX_STEP = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_volt,
   input  logic [SMP_W-1:0] smp_curr,
   input  logic             cyc_start,
   output logic [IDX_W-1:0] idx_out,
   output logic             idx_valid
);
   import trk_pkg::*;

   localparam int unsigned ACC_W = SMP_W + CNT_W;
   localparam int unsigned PWR_W = 2 * SMP_W;

   if (IDX_MIN > IDX_INIT || IDX_INIT > IDX_MAX) begin : g_bad_init
      $error("mppt_cycle_tracker: IDX_INIT must lie within the limits");
   end
   if (IDX_STEP == 0 || IDX_STEP > IDX_MAX - IDX_MIN) begin : g_bad_step
      $error("mppt_cycle_tracker: IDX_STEP out of range");
   end
   if (IDX_MAX >= (1 << IDX_W)) begin : g_bad_max
      $error("mppt_cycle_tracker: IDX_MAX does not fit IDX_W");
   end

   logic [TRK_CH-1:0][SMP_W-1:0] smp;
   logic [TRK_CH-1:0][ACC_W-1:0] snap_sum;
   logic [TRK_CH-1:0][ACC_W-1:0] quo;
   logic [TRK_CH-1:0]            div_busy, div_done;
   logic [CNT_W-1:0]             snap_cnt;
   logic                         snap_vld, go, eng_busy;
   logic [PWR_W-1:0]             pwr_r;
   logic                         pwr_vld;
   logic [IDX_W-1:0]             pend;

   assign smp[0] = smp_volt;
   assign smp[1] = smp_curr;

   trk_win_acc #(.SMP_W(SMP_W), .CNT_W(CNT_W)) acc_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp(smp),
      .cyc_start(cyc_start), .snap_sum(snap_sum), .snap_cnt(snap_cnt),
      .snap_vld(snap_vld)
   );

   // a window that closes while the previous one is still in flight is dropped
   assign eng_busy = (|div_busy) | (|div_done) | pwr_vld;
   assign go       = snap_vld && (snap_cnt != '0) && !eng_busy;

   for (genvar ch = 0; ch < TRK_CH; ch++) begin : g_div
      trk_seq_div #(.NUM_W(ACC_W), .DEN_W(CNT_W)) div_i (
         .clk(clk), .rst_n(rst_n), .start(go), .num(snap_sum[ch]),
         .den(snap_cnt), .busy(div_busy[ch]), .done(div_done[ch]),
         .quo(quo[ch])
      );

      // R4: a mean never leaves the sample range
      mean_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         div_done[ch] |-> (quo[ch][ACC_W-1:SMP_W] == '0));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pwr_r   <= '0;
         pwr_vld <= 1'b0;
      end else begin
         pwr_vld <= div_done[0];
         if (div_done[0])
            pwr_r <= PWR_W'(quo[0][SMP_W-1:0]) * PWR_W'(quo[1][SMP_W-1:0]);
      end
   end

   trk_step_ctl #(
      .IDX_W(IDX_W), .PWR_W(PWR_W), .IDX_MIN(IDX_MIN), .IDX_MAX(IDX_MAX),
      .IDX_INIT(IDX_INIT), .IDX_STEP(IDX_STEP)
   ) step_i (
      .clk(clk), .rst_n(rst_n), .dec_en(pwr_vld), .pwr(pwr_r), .pend(pend)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_out   <= IDX_W'(IDX_INIT);
         idx_valid <= 1'b0;
      end else begin
         idx_valid <= cyc_start;
         if (cyc_start)
            idx_out <= pend;
      end
   end

   // R2
   idx_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_out != $past(idx_out)) |-> $past(cyc_start));
   // R2
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> idx_valid);
   // R2
   valid_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      idx_valid |-> $past(cyc_start));
   // R2
   div_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      div_done[0] == div_done[1]);
endmodule

// File: tb/mppt_cycle_tracker_tb_top.sv
module mppt_cycle_tracker_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SW    = 6;
   localparam int CW    = 5;
   localparam int MW    = 6;
   localparam int IMIN  = 8;
   localparam int IMAX  = 40;
   localparam int IINIT = 20;
   localparam int ISTEP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic          cyc_start = 1'b0;
   logic [SW-1:0] smp_volt = '0;
   logic [SW-1:0] smp_curr = '0;
   logic [MW-1:0] idx_out;
   logic          idx_valid;

   int      n_chk = 0;
   int      n_err = 0;
   int      m_pend = IINIT;
   int      m_dir = 1;
   int      m_hit = 0;
   longint  m_prev = 0;
   int      m_first = 1;
   string   m_tag = "R3";
   int      w_n = 0;
   int      w_sv = 0;
   int      w_si = 0;
   bit [15:0] lf = 16'hACE1;

   mppt_cycle_tracker #(
      .SMP_W(SW), .CNT_W(CW), .IDX_W(MW), .IDX_MIN(IMIN), .IDX_MAX(IMAX),
      .IDX_INIT(IINIT), .IDX_STEP(ISTEP)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_volt(smp_volt),
      .smp_curr(smp_curr), .cyc_start(cyc_start), .idx_out(idx_out),
      .idx_valid(idx_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   function automatic int rnd();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      return int'(lf);
   endfunction

   // hill-climbing reference model applied to the window just closed
   task automatic decide();
      longint p;
      int nx;
      if (w_n == 0) begin
         m_tag = "R8";
         return;
      end
      p = longint'(w_sv / w_n) * longint'(w_si / w_n);
      m_tag = m_first ? "R6" : "R5";
      if (m_hit != 0) begin
         m_dir = 1 - m_dir;
         m_hit = 0;
         m_tag = "R7";
      end else if (p < m_prev) begin
         m_dir = 1 - m_dir;
      end
      m_prev = p;
      nx = (m_dir != 0) ? m_pend + ISTEP : m_pend - ISTEP;
      if (nx > IMAX) begin nx = IMAX; m_hit = 1; m_tag = "R7"; end
      if (nx < IMIN) begin nx = IMIN; m_hit = 1; m_tag = "R7"; end
      m_pend  = nx;
      m_first = 0;
   endtask

   task automatic put(input int v, input int i);
      smp_valid = 1'b1;
      smp_volt  = SW'(v);
      smp_curr  = SW'(i);
      w_sv += v;
      w_si += i;
      w_n++;
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic strobe(input bit ws, input int v, input int i, input string tg);
      int    exp_idx;
      string t;
      exp_idx = m_pend;
      t = m_tag;
      cyc_start = 1'b1;
      if (ws) begin
         smp_valid = 1'b1;
         smp_volt  = SW'(v);
         smp_curr  = SW'(i);
      end
      @(negedge clk);
      cyc_start = 1'b0;
      smp_valid = 1'b0;
      chk({t, " latched index (R3)"}, int'(idx_out), exp_idx);
      chk("R2 valid pulse", int'(idx_valid), 1);
      decide();
      if (tg != "") m_tag = tg;
      w_n  = ws ? 1 : 0;
      w_sv = ws ? v : 0;
      w_si = ws ? i : 0;
      @(negedge clk);
      chk("R2 valid lasts one clock", int'(idx_valid), 0);
      repeat (18) @(negedge clk);
      chk("R2 index held between strobes", int'(idx_out), exp_idx);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 index in reset", int'(idx_out), IINIT);
      chk("R1 valid in reset", int'(idx_valid), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1 index after reset", int'(idx_out), IINIT);
      chk("R1 valid after reset", int'(idx_valid), 0);

      // empty first window (R8), then rising power drives both limits (R7)
      strobe(1'b0, 0, 0, "");
      for (int k = 0; k < 14; k++) begin
         for (int s = 0; s < 5; s++) put(10 + k + (s % 2), 12 + k);
         strobe(1'b0, 0, 0, "");
      end

      // floor averaging and a sample coincident with the strobe (R4)
      put(3, 50); put(4, 51); put(4, 51);
      strobe(1'b1, 30, 30, "R4");
      put(31, 29); put(30, 30);
      strobe(1'b0, 0, 0, "R4");
      strobe(1'b0, 0, 0, "");
      strobe(1'b0, 0, 0, "");

      // pseudo-random sweep over counts 0..8 and full sample range
      for (int w = 0; w < 48; w++) begin
         int n;
         n = rnd() % 9;
         for (int s = 0; s < n; s++) put(rnd() % 64, rnd() % 64);
         strobe(1'b0, 0, 0, "");
      end
      strobe(1'b0, 0, 0, "");

      summary();
      $finish;
   end
endmodule